// File: doc/BRIEF.md
# Handshaked Byte Parallel Port

This block is one channel of an 8-bit parallel port. The channel moves bytes between a processor and a peripheral and paces each transfer with a two-wire handshake. The port drives a ready line, and the peripheral answers on an active-low strobe line. Software picks the transfer direction with a control word. The choices are byte output, byte input, a bidirectional mode, and a bit-control mode. In bit-control mode the per-bit logic lives elsewhere, so this channel keeps its handshake idle.

The processor side has three single-cycle pulses: a data-register write, a control-register write and a data-register read. The write byte is shared by both writes. The bidirectional mode exists only on the instance built as the primary port. In that mode the channel's own handshake pair paces output, and a second, borrowed pair paces input. In chip wiring the borrowed pair is the companion port's pair. When a transfer completes and interrupts are enabled, the channel raises a held interrupt request.

Top module: `hs_port`

## Requirements
- R1: After synchronous reset the channel is in input mode. `rdy_o`, `alt_rdy_o`, `irq_o` and `pin_oe_o` are 0, and `rdata_o` reads 0.
- R2: A control write whose byte has bits [5:4]=00 and bits [3:0]=4'hF is a mode word. Bits [7:6] carry the mode: 00 output, 01 input, 10 bidirectional, 11 bit control. An accepted mode word has these effects on the next cycle:
  - `rdy_o` is 1 only for input mode.
  - `alt_rdy_o` is 1 only for bidirectional mode.
  - Any pending interrupt is dropped.
  - A control byte with any other low nibble changes no mode.
- R3: On an instance built with `IS_PORT_A`=0, a mode word that asks for bidirectional mode is ignored, and the previous mode stays.
- R4: In output mode, a data write has these effects, visible from the next cycle:
  - It latches the byte onto `pin_o`.
  - It sets `rdy_o`.
  - `rdata_o` returns that byte.
  - `pin_oe_o` is 1 throughout output mode.
- R5: In output mode, a rising edge of `stb_n_i` (low in one cycle, high in the next) while `rdy_o` is 1 clears `rdy_o` and completes the transfer. A rising edge while `rdy_o` is 0 completes nothing. If a data write coincides with the rising edge, the write wins and `rdy_o` stays 1.
- R6: In input mode, every cycle with `stb_n_i` low captures `pin_i` into the input latch and clears `rdy_o`. The following rising edge of `stb_n_i` completes the transfer. `rdata_o` returns the input latch.
- R7: In input mode, a data read sets `rdy_o` on the next cycle, unless `stb_n_i` is low in that cycle; in that case `rdy_o` stays 0.
- R8: In bidirectional mode the output side follows R4/R5 on `stb_n_i`/`rdy_o`, and `pin_oe_o` is 1 only while `stb_n_i` is low. The input side follows R6/R7 on `alt_stb_n_i`/`alt_rdy_o`.
- R9: Interrupt enable works as follows:
  - A control write with bits [5:4]=00 and bits [3:0]=4'h7 sets the interrupt enable from bit 7.
  - A completion while enabled sets `irq_o`.
  - A completion while disabled leaves `irq_o` at 0.
  - Writing the enable as 0 clears a pending request.
- R10: A data read or a data write clears `irq_o` on the next cycle, unless a completion occurs in the same cycle.
- R11: In bit-control mode, `rdy_o`, `alt_rdy_o` and `pin_oe_o` stay 0. Strobes on either pair and data writes raise neither ready nor interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wdata_i | input | DW | Byte for data and control writes |
| data_wr_i | input | 1 | Data-register write pulse |
| ctrl_wr_i | input | 1 | Control-register write pulse |
| data_rd_i | input | 1 | Data-register read pulse |
| rdata_o | output | DW | Output latch in output mode, otherwise input latch |
| pin_i | input | DW | Peripheral data pins, inbound |
| pin_o | output | DW | Output latch to the pins |
| pin_oe_o | output | 1 | Pin drive enable |
| stb_n_i | input | 1 | Active-low strobe of the channel's own pair |
| rdy_o | output | 1 | Ready of the channel's own pair |
| alt_stb_n_i | input | 1 | Active-low strobe of the borrowed input pair (bidirectional mode) |
| alt_rdy_o | output | 1 | Ready of the borrowed input pair |
| irq_o | output | 1 | Held interrupt request |

## Verification
Output and input transfers are swept over all 256 byte values.

- **Output sweep.** Each value tells apart bit-lane swaps and stuck bits on the latch. Each pass also proves that a low strobe alone leaves ready standing, while its release completes the transfer.
- **Input sweep.** The pin value changes while the strobe is held low. This separates per-cycle capture from a capture taken only at the strobe edge.
- **Collisions.** A write that lands on the strobe release and a read that lands inside a low strobe settle the priority between setting and clearing ready.
- **Mode checks.** Bidirectional transfers, bit-control quiescence, an illegal low nibble and a bidirectional request on a secondary instance each show whether a mode change took effect.

// File: rtl/hs_port_pkg.sv
// Shared types for the handshaked byte port.
// Assumes a 2-bit mode field as defined in the brief.
package hs_port_pkg;
    typedef enum logic [1:0] {
        MODE_OUT   = 2'd0,
        MODE_IN    = 2'd1,
        MODE_BIDIR = 2'd2,
        MODE_BIT   = 2'd3
    } hs_mode_e;

    localparam logic [3:0] TAG_MODE = 4'hF;
    localparam logic [3:0] TAG_IRQ  = 4'h7;
endpackage

// File: rtl/hs_port_ctrl.sv
// Control-word decoder: holds the transfer mode and the interrupt enable.
// Assumes control bytes carry a tag in [3:0] and zero in [5:4].
// Refuses bidirectional mode when the channel is not the primary port.
module hs_port_ctrl
    import hs_port_pkg::*;
#(
    parameter int DW        = 8,
    parameter bit IS_PORT_A = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr_i,
    input  logic [DW-1:0] wdata_i,
    output hs_mode_e      mode_o,
    output hs_mode_e      new_mode_o,
    output logic          mode_load_o,
    output logic          ie_o,
    output logic          ie_off_o
);
    logic     tag_ok;
    logic     is_mode_word;
    logic     is_irq_word;
    hs_mode_e req_mode;

    // Decode the tag and whether the requested mode is legal here.
    always_comb begin
        tag_ok       = ctrl_wr_i && (wdata_i[5:4] == 2'b00);
        is_mode_word = tag_ok && (wdata_i[3:0] == TAG_MODE);
        is_irq_word  = tag_ok && (wdata_i[3:0] == TAG_IRQ);
        req_mode     = hs_mode_e'(wdata_i[7:6]);
        mode_load_o  = is_mode_word && (IS_PORT_A || (req_mode != MODE_BIDIR));
        new_mode_o   = req_mode;
        ie_off_o     = is_irq_word && !wdata_i[7];
    end

    // Hold mode and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= MODE_IN;
            ie_o   <= 1'b0;
        end else begin
            if (mode_load_o) mode_o <= req_mode;
            if (is_irq_word) ie_o   <= wdata_i[7];
        end
    end
endmodule

// File: rtl/hs_port_strobe.sv
// Strobe sampler: reports the low level and the rising edge of an active-low strobe.
// Assumes the strobe is already synchronous to clk.
module hs_port_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_n_i,
    output logic low_o,
    output logic rise_o
);
    logic stb_q;

    // Remember last cycle's strobe level (idle high).
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b1;
        else        stb_q <= stb_n_i;
    end

    // Level and edge derived from the current and the remembered sample.
    always_comb begin
        low_o  = !stb_n_i;
        rise_o = stb_n_i && !stb_q;
    end
endmodule

// File: rtl/hs_port_irq.sv
// Interrupt pending flag: set on a completed transfer while enabled.
// Cleared by a flush or by a data access; a completion wins over the access clear.
module hs_port_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic done_i,
    input  logic ie_i,
    input  logic access_i,
    output logic irq_o
);
    // Track the pending request.
    always_ff @(posedge clk) begin
        if (!rst_n)              irq_o <= 1'b0;
        else if (flush_i)        irq_o <= 1'b0;
        else if (done_i && ie_i) irq_o <= 1'b1;
        else if (access_i)       irq_o <= 1'b0;
    end
endmodule

// File: rtl/hs_port.sv
// Handshaked byte parallel port channel (top).
// Pair 0 is the channel's own strobe/ready; pair 1 is borrowed for input in bidirectional mode.
// Assumes single-cycle processor pulses and synchronous strobes.
module hs_port
    import hs_port_pkg::*;
#(
    parameter int DW        = 8,
    parameter bit IS_PORT_A = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] wdata_i,
    input  logic          data_wr_i,
    input  logic          ctrl_wr_i,
    input  logic          data_rd_i,
    output logic [DW-1:0] rdata_o,
    input  logic [DW-1:0] pin_i,
    output logic [DW-1:0] pin_o,
    output logic          pin_oe_o,
    input  logic          stb_n_i,
    output logic          rdy_o,
    input  logic          alt_stb_n_i,
    output logic          alt_rdy_o,
    output logic          irq_o
);
    localparam int NPAIR = 2;

    hs_mode_e         mode_q;
    hs_mode_e         new_mode;
    logic             mode_load;
    logic             ie_q;
    logic             ie_off;
    logic [NPAIR-1:0] stb_vec;
    logic [NPAIR-1:0] low;
    logic [NPAIR-1:0] rise;
    logic             rdy_d, alt_d;
    logic             done;
    logic [DW-1:0]    out_q, in_q;

    hs_port_ctrl #(.DW(DW), .IS_PORT_A(IS_PORT_A)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr_i   (ctrl_wr_i),
        .wdata_i     (wdata_i),
        .mode_o      (mode_q),
        .new_mode_o  (new_mode),
        .mode_load_o (mode_load),
        .ie_o        (ie_q),
        .ie_off_o    (ie_off)
    );

    assign stb_vec = {alt_stb_n_i, stb_n_i};

    // One strobe sampler per handshake pair.
    for (genvar g = 0; g < NPAIR; g++) begin : g_stb
        hs_port_strobe u_stb (
            .clk     (clk),
            .rst_n   (rst_n),
            .stb_n_i (stb_vec[g]),
            .low_o   (low[g]),
            .rise_o  (rise[g])
        );
    end

    // Next ready states and transfer completion per mode.
    always_comb begin
        rdy_d = rdy_o;
        alt_d = alt_rdy_o;
        done  = 1'b0;
        if (mode_load) begin
            rdy_d = (new_mode == MODE_IN);
            alt_d = (new_mode == MODE_BIDIR);
        end else begin
            unique case (mode_q)
                MODE_OUT: begin
                    done  = rise[0] && rdy_o;
                    if (data_wr_i)    rdy_d = 1'b1;
                    else if (rise[0]) rdy_d = 1'b0;
                    alt_d = 1'b0;
                end
                MODE_IN: begin
                    done  = rise[0];
                    if (low[0])         rdy_d = 1'b0;
                    else if (data_rd_i) rdy_d = 1'b1;
                    alt_d = 1'b0;
                end
                MODE_BIDIR: begin
                    done  = (rise[0] && rdy_o) || rise[1];
                    if (data_wr_i)    rdy_d = 1'b1;
                    else if (rise[0]) rdy_d = 1'b0;
                    if (low[1])         alt_d = 1'b0;
                    else if (data_rd_i) alt_d = 1'b1;
                end
                default: begin
                    rdy_d = 1'b0;
                    alt_d = 1'b0;
                end
            endcase
        end
    end

    // Ready flops and data latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_o     <= 1'b0;
            alt_rdy_o <= 1'b0;
            out_q     <= '0;
            in_q      <= '0;
        end else begin
            rdy_o     <= rdy_d;
            alt_rdy_o <= alt_d;
            if (data_wr_i && (mode_q == MODE_OUT || mode_q == MODE_BIDIR))
                out_q <= wdata_i;
            if ((mode_q == MODE_IN && low[0]) || (mode_q == MODE_BIDIR && low[1]))
                in_q <= pin_i;
        end
    end

    hs_port_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (mode_load || ie_off),
        .done_i   (done),
        .ie_i     (ie_q),
        .access_i (data_wr_i || data_rd_i),
        .irq_o    (irq_o)
    );

    // Pin drive and read-back selection.
    always_comb begin
        pin_o    = out_q;
        pin_oe_o = (mode_q == MODE_OUT) || (mode_q == MODE_BIDIR && low[0]);
        rdata_o  = (mode_q == MODE_OUT) ? out_q : in_q;
    end
endmodule

// File: rtl/hs_port_chk.sv
// Protocol checker for hs_port, attached by bind; watches ports and mode/enable state.
module hs_port_chk
    import hs_port_pkg::*;
#(
    parameter int DW        = 8,
    parameter bit IS_PORT_A = 1'b1
) (
    input logic     clk,
    input logic     rst_n,
    input logic     stb_n_i,
    input logic     data_wr_i,
    input logic     data_rd_i,
    input logic     ctrl_wr_i,
    input logic     rdy_o,
    input logic     alt_rdy_o,
    input logic     irq_o,
    input logic     pin_oe_o,
    input hs_mode_e mode_q,
    input logic     ie_q
);
    logic stb_prev;

    // Independent record of the previous strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_prev <= 1'b1;
        else        stb_prev <= stb_n_i;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!rdy_o && !alt_rdy_o && !irq_o));

    assert_b_no_bidir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !IS_PORT_A |-> (mode_q != MODE_BIDIR));

    assert_write_readies_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MODE_OUT || mode_q == MODE_BIDIR) && data_wr_i && !ctrl_wr_i) |=> rdy_o);

    assert_rise_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OUT && rdy_o && stb_n_i && !stb_prev && !data_wr_i && !ctrl_wr_i)
        |=> !rdy_o);

    assert_read_readies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IN && data_rd_i && stb_n_i && !ctrl_wr_i) |=> rdy_o);

    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(ie_q));

    assert_bitmode_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BIT) |-> (!rdy_o && !alt_rdy_o && !pin_oe_o));
endmodule

bind hs_port hs_port_chk #(.DW(DW), .IS_PORT_A(IS_PORT_A)) u_chk (.*);

// File: tb/hs_port_bench.sv
// Self-checking bench for hs_port: primary instance swept over all bytes,
// secondary instance used for the bidirectional refusal.
module hs_port_bench;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] wdata = '0, pin_i = '0;
    logic          data_wr = 1'b0, ctrl_wr = 1'b0, data_rd = 1'b0;
    logic          stb_n = 1'b1, alt_stb_n = 1'b1;
    logic [DW-1:0] rdata, pin_o;
    logic          pin_oe, rdy, alt_rdy, irq;
    logic          ctrl_wr_b = 1'b0, data_wr_b = 1'b0;
    logic [DW-1:0] rdata_b, pin_o_b;
    logic          pin_oe_b, rdy_b, alt_rdy_b, irq_b;
    int            n_chk = 0, n_bad = 0, cyc = 0;

    always #10 clk = ~clk;

    hs_port #(.DW(DW), .IS_PORT_A(1'b1)) u_hs_port (
        .clk(clk), .rst_n(rst_n), .wdata_i(wdata), .data_wr_i(data_wr),
        .ctrl_wr_i(ctrl_wr), .data_rd_i(data_rd), .rdata_o(rdata), .pin_i(pin_i),
        .pin_o(pin_o), .pin_oe_o(pin_oe), .stb_n_i(stb_n), .rdy_o(rdy),
        .alt_stb_n_i(alt_stb_n), .alt_rdy_o(alt_rdy), .irq_o(irq)
    );

    hs_port #(.DW(DW), .IS_PORT_A(1'b0)) u_hs_port_b (
        .clk(clk), .rst_n(rst_n), .wdata_i(wdata), .data_wr_i(data_wr_b),
        .ctrl_wr_i(ctrl_wr_b), .data_rd_i(1'b0), .rdata_o(rdata_b), .pin_i(pin_i),
        .pin_o(pin_o_b), .pin_oe_o(pin_oe_b), .stb_n_i(1'b1), .rdy_o(rdy_b),
        .alt_stb_n_i(1'b1), .alt_rdy_o(alt_rdy_b), .irq_o(irq_b)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ctrl(logic [7:0] b);
        wdata = b; ctrl_wr = 1'b1; tick(); ctrl_wr = 1'b0;
    endtask

    task automatic dwr(logic [7:0] b);
        wdata = b; data_wr = 1'b1; tick(); data_wr = 1'b0;
    endtask

    task automatic drd();
        data_rd = 1'b1; tick(); data_rd = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        // R1 reset state
        check("R1 rdy", rdy, 0);  check("R1 alt_rdy", alt_rdy, 0);
        check("R1 irq", irq, 0);  check("R1 oe", pin_oe, 0);
        check("R1 rdata", rdata, 0);
        rst_n = 1'b1; tick();

        // R9 enable, R2 output mode
        ctrl(8'h87);
        ctrl(8'h0F);
        check("R2 out rdy", rdy, 0);
        check("R4 out oe", pin_oe, 1);

        // R4/R5/R9/R10 output sweep
        for (int v = 0; v < 256; v++) begin
            dwr(v[7:0]);
            check("R4 pin", pin_o, v);  check("R4 rdy", rdy, 1);
            check("R4 rdata", rdata, v); check("R10 wr clears irq", irq, 0);
            stb_n = 1'b0; tick();
            check("R5 low keeps rdy", rdy, 1);
            stb_n = 1'b1; tick();
            check("R5 rise clears rdy", rdy, 0);
            check("R9 irq on done", irq, 1);
        end
        drd();
        check("R10 rd clears irq", irq, 0);
        stb_n = 1'b0; tick(); stb_n = 1'b1; tick();
        check("R5 no rdy no done", irq, 0);
        check("R5 rdy stays low", rdy, 0);

        // R5 write coinciding with strobe release
        dwr(8'h5A);
        stb_n = 1'b0; tick();
        stb_n = 1'b1; wdata = 8'hA5; data_wr = 1'b1; tick(); data_wr = 1'b0;
        check("R5 write wins rdy", rdy, 1);
        check("R5 new byte", pin_o, 8'hA5);
        check("R10 done beats clear", irq, 1);

        // R9 disable clears, and no irq while disabled
        ctrl(8'h07);
        check("R9 disable clears", irq, 0);
        stb_n = 1'b0; tick(); stb_n = 1'b1; tick();
        check("R9 no irq disabled", irq, 0);
        check("R5 rdy cleared", rdy, 0);

        // R2 input mode, R6/R7 sweep
        ctrl(8'h4F);
        check("R2 in rdy", rdy, 1);
        check("R2 in oe", pin_oe, 0);
        ctrl(8'h87);
        for (int v = 0; v < 256; v++) begin
            pin_i = v[7:0]; stb_n = 1'b0; tick();
            check("R6 rdy low", rdy, 0);
            check("R6 capture", rdata, v);
            pin_i = ~v[7:0]; tick();
            check("R6 recapture", rdata, {24'd0, ~v[7:0]});
            stb_n = 1'b1; tick();
            check("R6 done irq", irq, 1);
            check("R6 rdy held", rdy, 0);
            drd();
            check("R7 read readies", rdy, 1);
            check("R10 rd clears irq", irq, 0);
        end
        // R7 read inside a low strobe
        stb_n = 1'b0; data_rd = 1'b1; tick(); data_rd = 1'b0;
        check("R7 low wins", rdy, 0);
        stb_n = 1'b1; tick();
        drd();
        check("R7 read after", rdy, 1);

        // R8 bidirectional
        ctrl(8'h8F);
        check("R2 bidir rdy", rdy, 0);
        check("R2 bidir alt", alt_rdy, 1);
        check("R2 mode clears irq", irq, 0);
        check("R8 oe idle", pin_oe, 0);
        dwr(8'hC3);
        check("R8 out rdy", rdy, 1);
        stb_n = 1'b0; #1;
        check("R8 oe during stb", pin_oe, 1);
        check("R8 pin", pin_o, 8'hC3);
        tick(); stb_n = 1'b1; tick();
        check("R8 out done rdy", rdy, 0);
        check("R8 oe released", pin_oe, 0);
        check("R8 out irq", irq, 1);
        pin_i = 8'h3C; alt_stb_n = 1'b0; tick();
        check("R8 alt rdy low", alt_rdy, 0);
        check("R8 alt capture", rdata, 8'h3C);
        alt_stb_n = 1'b1; tick();
        drd();
        check("R8 alt rdy back", alt_rdy, 1);
        alt_stb_n = 1'b0; tick(); alt_stb_n = 1'b1; tick();
        check("R8 alt irq", irq, 1);

        // R11 bit control
        ctrl(8'hCF);
        check("R11 rdy", rdy, 0); check("R11 alt", alt_rdy, 0);
        check("R11 oe", pin_oe, 0); check("R2 mode clears irq", irq, 0);
        stb_n = 1'b0; alt_stb_n = 1'b0; tick();
        stb_n = 1'b1; alt_stb_n = 1'b1; tick();
        dwr(8'h11);
        check("R11 no irq", irq, 0); check("R11 rdy after write", rdy, 0);
        // R2 bad tag is not a mode word
        ctrl(8'h4E);
        check("R2 bad tag ignored", rdy, 0);

        // R3 secondary instance refuses bidirectional mode
        wdata = 8'h0F; ctrl_wr_b = 1'b1; tick(); ctrl_wr_b = 1'b0;
        check("R3 b out oe", pin_oe_b, 1);
        wdata = 8'h8F; ctrl_wr_b = 1'b1; tick(); ctrl_wr_b = 1'b0;
        check("R3 b oe kept", pin_oe_b, 1);
        check("R3 b alt low", alt_rdy_b, 0);
        wdata = 8'h77; data_wr_b = 1'b1; tick(); data_wr_b = 1'b0;
        check("R3 b still output", rdy_b, 1);
        check("R3 b pin", pin_o_b, 8'h77);

        summary();
        $finish;
    end
endmodule